// File: doc/BRIEF.md
# Insertion-Policy Recency Controller for One Cache Set

This block keeps the recency order of a single set in a set-associative cache. Each way carries a rank, where rank 0 is the most recently used way and rank WAYS-1 is the least recently used way. On every lookup the block updates the ranks. A hit always promotes the accessed way to the front. On a miss the block names the way to be refilled. It then places the new line either at the front or at the back of the order, depending on the selected insertion mode.

The block supports three insertion modes. Front insertion is classic LRU. Back insertion keeps a fixed part of an oversized looping working set resident, instead of thrashing the whole set. The coin-flip mode sends only a small power-of-two fraction of misses to the front. Its decisions come from an internal LFSR that advances once per miss. No state beyond the ranks and the per-way valid bits is needed.

Tag matching, data storage and the choice of mode across sets belong to the surrounding cache.

Top module: `ins_lru_set`

## Requirements
- R1: When all ways are valid, `victim_way` is the way whose rank is WAYS-1, in every mode.
- R2: While any way is invalid, `victim_way` is the lowest-numbered invalid way. A miss sets the valid bit of that way, and valid bits clear only on reset.
- R3: A hit moves `hit_way` to rank 0. Every way ranked ahead of it moves back by one, and the other ways keep their ranks.
- R4: With `policy` 2'b00 or 2'b11, a miss puts the refilled way at rank 0 and moves the ways ranked ahead of it back by one.
- R5: With `policy` 2'b01, a miss puts the refilled way at rank WAYS-1, and every way ranked behind its old rank moves forward by one.
- R6: With `policy` 2'b10 and `throttle` t, a miss uses R4 placement with probability 2^-t and R5 placement otherwise. A t of 0 always gives R4 placement. A t of LFSR_W or more always gives R5 placement.
- R7: Reset gives way i rank i, with all ways invalid. After every update the ranks form a permutation of 0..WAYS-1.
- R8: Consider a loop over 6 distinct lines on a 4-way set, with misses and hits decided by tag. After the first pass, R5 placement yields 3 hits per pass and R4 placement yields none.
- R9: While `lookup_valid` is low, the ranks and the valid bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_valid | input | 1 | A lookup is applied this cycle |
| hit | input | 1 | The lookup hit in `hit_way` |
| hit_way | input | log2(WAYS) | Way that hit |
| policy | input | 2 | 00/11 front insertion, 01 back insertion, 10 coin-flip insertion |
| throttle | input | log2(LFSR_W+1) | Coin-flip exponent t; front insertion chance is 2^-t |
| victim_way | output | log2(WAYS) | Way that a miss refills |
| ranks | output | WAYS*log2(WAYS) | Rank of way i in bits [i*log2(WAYS) +: log2(WAYS)]; 0 is most recent |
| valid_mask | output | WAYS | Per-way valid bits |

## Verification
The assertions assume that a hit names a way that is already valid. They also assume that the surrounding cache refills `victim_way` on every miss. The bench satisfies both by driving its own tag model: it decides hit or miss from tags it has itself written into the ways reported by `victim_way`, and it never asserts `hit` for an empty way. Coin-flip placement with a middle throttle value cannot be predicted cycle by cycle. For those misses the bench checks only that the refilled way lands at rank 0 or at rank WAYS-1, and it checks the front-insertion fraction over many misses against a tolerance band.

// File: rtl/ins_lru_set.sv
module ins_lru_set #(
  parameter int WAYS = 4,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 'hB400,
  localparam int IW = $clog2(WAYS),
  localparam int TW = $clog2(LFSR_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lookup_valid,
  input  logic                 hit,
  input  logic [IW-1:0]        hit_way,
  input  logic [1:0]           policy,
  input  logic [TW-1:0]        throttle,
  output logic [IW-1:0]        victim_way,
  output logic [WAYS*IW-1:0]   ranks,
  output logic [WAYS-1:0]      valid_mask
);
  localparam logic [IW-1:0] BACK = IW'(WAYS - 1);

  logic [IW-1:0]     rank_q [WAYS];
  logic [IW-1:0]     rank_d [WAYS];
  logic [WAYS-1:0]   valid_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic [IW-1:0]     lru_way, fill_way, mover, old_rank;
  logic [TW-1:0]     tcl;
  logic              coin, to_front, miss;

  always_comb begin
    lru_way  = '0;
    fill_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_q[i]) fill_way = IW'(i);
      if (rank_q[i] == BACK) lru_way = IW'(i);
    end
  end

  assign victim_way = (&valid_q) ? lru_way : fill_way;
  assign miss       = lookup_valid && !hit;

  assign tcl      = (throttle > TW'(LFSR_W)) ? TW'(LFSR_W) : throttle;
  assign coin     = (lfsr_q & ~({LFSR_W{1'b1}} << tcl)) == '0;
  assign to_front = hit || (policy == 2'b00) || (policy == 2'b11) || ((policy == 2'b10) && coin);
  assign mover    = hit ? hit_way : victim_way;
  assign old_rank = rank_q[mover];

  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      if (IW'(i) == mover)
        rank_d[i] = to_front ? '0 : BACK;
      else if (to_front && rank_q[i] < old_rank)
        rank_d[i] = rank_q[i] + 1'b1;
      else if (!to_front && rank_q[i] > old_rank)
        rank_d[i] = rank_q[i] - 1'b1;
      else
        rank_d[i] = rank_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) rank_q[i] <= IW'(i);
      valid_q <= '0;
      lfsr_q  <= LFSR_W'(1);
    end else if (lookup_valid) begin
      for (int i = 0; i < WAYS; i++) rank_q[i] <= rank_d[i];
      if (miss) begin
        valid_q[victim_way] <= 1'b1;
        lfsr_q <= (lfsr_q >> 1) ^ (lfsr_q[0] ? LFSR_TAPS : '0);
      end
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_out
    assign ranks[g*IW +: IW] = rank_q[g];
  end
  assign valid_mask = valid_q;
endmodule

module ins_lru_set_chk #(
  parameter int WAYS = 4,
  parameter int LFSR_W = 16,
  localparam int IW = $clog2(WAYS),
  localparam int TW = $clog2(LFSR_W + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lookup_valid,
  input logic               hit,
  input logic [IW-1:0]      hit_way,
  input logic [1:0]         policy,
  input logic [TW-1:0]      throttle,
  input logic [IW-1:0]      victim_way,
  input logic [WAYS*IW-1:0] ranks,
  input logic [WAYS-1:0]    valid_mask
);
  localparam logic [IW-1:0] BACK = IW'(WAYS - 1);
  logic [WAYS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < WAYS; i++) seen[ranks[i*IW +: IW]] = 1'b1;
  end

  // R1
  lru_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&valid_mask) |-> ranks[victim_way*IW +: IW] == BACK);
  // R2
  fill_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&valid_mask) |-> !valid_mask[victim_way]);
  // R2
  fill_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && !hit) |=> valid_mask[$past(victim_way)]);
  // R2
  valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (valid_mask & $past(valid_mask)) == $past(valid_mask));
  // R3
  hit_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && hit) |=> ranks[$past(hit_way)*IW +: IW] == '0);
  // R3
  hit_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && hit) |-> valid_mask[hit_way]);
  // R4
  front_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && !hit && policy == 2'b00) |=> ranks[$past(victim_way)*IW +: IW] == '0);
  // R5
  back_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && !hit && policy == 2'b01) |=> ranks[$past(victim_way)*IW +: IW] == BACK);
  // R6
  coin_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && !hit && policy == 2'b10 && throttle == '0) |=> ranks[$past(victim_way)*IW +: IW] == '0);
  // R7
  perm_chk: assert property (@(posedge clk) disable iff (!rst_n) &seen);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> $stable(ranks) && $stable(valid_mask));
endmodule

bind ins_lru_set ins_lru_set_chk #(.WAYS(WAYS), .LFSR_W(LFSR_W)) u_chk (.*);

// File: tb/tb_ins_lru_set.sv
`timescale 1ns/1ps
module tb_ins_lru_set;
  localparam int WAYS = 4;
  localparam int IW = 2;
  localparam int TW = 5;

  logic clk = 0, rst_n = 0, lookup_valid = 0, hit = 0;
  logic [IW-1:0] hit_way = 0;
  logic [1:0] policy = 0;
  logic [TW-1:0] throttle = 0;
  logic [IW-1:0] victim_way;
  logic [WAYS*IW-1:0] ranks;
  logic [WAYS-1:0] valid_mask;

  ins_lru_set #(.WAYS(WAYS)) dut (.*);

  always #2 clk = ~clk;

  typedef struct { logic [WAYS*IW-1:0] r; logic [WAYS-1:0] v; string tag; } exp_t;
  exp_t expq[$];
  int checks = 0, fails = 0;
  bit predict_flag = 0, fired = 0, done = 0;
  int mr[WAYS];
  bit mv[WAYS];
  int tagw[WAYS];
  int front_cnt;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) fired <= lookup_valid && predict_flag;
  always @(negedge clk) begin
    if (fired && expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      chk(ranks == e.r, e.tag, "ranks", ranks, e.r);
      chk(valid_mask == e.v, e.tag, "valid", valid_mask, e.v);
    end
  end

  function automatic logic [WAYS*IW-1:0] model_ranks();
    logic [WAYS*IW-1:0] x;
    for (int i = 0; i < WAYS; i++) x[i*IW +: IW] = IW'(mr[i]);
    return x;
  endfunction
  function automatic logic [WAYS-1:0] model_valid();
    logic [WAYS-1:0] x;
    for (int i = 0; i < WAYS; i++) x[i] = mv[i];
    return x;
  endfunction
  function automatic int model_victim();
    for (int i = 0; i < WAYS; i++) if (!mv[i]) return i;
    for (int i = 0; i < WAYS; i++) if (mr[i] == WAYS - 1) return i;
    return 0;
  endfunction
  task automatic model_move(int w, bit front);
    int old = mr[w];
    for (int i = 0; i < WAYS; i++) begin
      if (i == w) continue;
      if (front && mr[i] < old) mr[i]++;
      else if (!front && mr[i] > old) mr[i]--;
    end
    mr[w] = front ? 0 : WAYS - 1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; lookup_valid = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    for (int i = 0; i < WAYS; i++) begin mr[i] = i; mv[i] = 0; tagw[i] = -1; end
  endtask

  task automatic do_lookup(bit h, int hw, int pol, int thr, output int vic);
    bit pred, front, allv;
    int mvic;
    string tag;
    @(negedge clk);
    lookup_valid = 1; hit = h; hit_way = IW'(hw); policy = 2'(pol); throttle = TW'(thr);
    #1;
    vic = victim_way;
    allv = &model_valid();
    if (!h) begin
      mvic = model_victim();
      chk(victim_way == IW'(mvic), allv ? "R1" : "R2", "victim", victim_way, mvic);
    end
    pred = h || pol != 2 || thr == 0 || thr >= 16;
    front = h || pol == 0 || pol == 3 || (pol == 2 && thr == 0);
    tag = h ? "R3" : (pol == 1 ? "R5" : (pol == 2 ? "R6" : "R4"));
    predict_flag = pred;
    if (pred) begin
      model_move(h ? hw : vic, front);
      if (!h) mv[vic] = 1;
      expq.push_back('{model_ranks(), model_valid(), tag});
    end
    @(posedge clk); #1;
    lookup_valid = 0;
    if (!pred) begin
      @(negedge clk);
      chk(ranks[vic*IW +: IW] == 0 || ranks[vic*IW +: IW] == WAYS - 1, "R6", "refill rank",
          ranks[vic*IW +: IW], 0);
      if (ranks[vic*IW +: IW] == 0) front_cnt++;
      for (int i = 0; i < WAYS; i++) mr[i] = ranks[i*IW +: IW];
      mv[vic] = 1;
    end
  endtask

  task automatic access(int addr, int pol, int thr, output bit was_hit);
    int hw = -1, vic;
    for (int i = 0; i < WAYS; i++) if (mv[i] && tagw[i] == addr) hw = i;
    was_hit = hw >= 0;
    do_lookup(was_hit, was_hit ? hw : 0, pol, thr, vic);
    if (!was_hit) tagw[vic] = addr;
  endtask

  task automatic loop_run(int pol, int thr, int exp_hits, string req);
    int hits = 0;
    bit h;
    do_reset();
    for (int p = 0; p < 9; p++)
      for (int a = 0; a < 6; a++) begin
        access(100 + a, pol, thr, h);
        if (p > 0 && h) hits++;
      end
    chk(hits == exp_hits, req, "loop hits", hits, exp_hits);
  endtask

  initial begin
    int vic;
    logic [WAYS*IW-1:0] hold_r;
    do_reset();
    @(negedge clk);
    // R7 reset state
    chk(ranks == 8'hE4, "R7", "reset ranks", ranks, 8'hE4);
    chk(valid_mask == 0, "R7", "reset valid", valid_mask, 0);
    chk(victim_way == 0, "R2", "reset victim", victim_way, 0);

    // R2 / R5 fills under back insertion, then R3 hit and R4 front insertion
    for (int i = 0; i < WAYS; i++) do_lookup(0, 0, 1, 0, vic);
    do_lookup(1, 2, 1, 0, vic);
    do_lookup(1, 3, 0, 0, vic);
    do_lookup(0, 0, 0, 0, vic);
    do_lookup(0, 0, 3, 0, vic);
    do_lookup(0, 0, 1, 0, vic);

    // R9 idle hold with noisy inputs
    @(negedge clk);
    hold_r = ranks;
    hit = 1; hit_way = 1; policy = 2'b10; throttle = 0;
    repeat (3) @(negedge clk);
    chk(ranks == hold_r, "R9", "idle ranks", ranks, hold_r);
    chk(valid_mask == 4'hF, "R9", "idle valid", valid_mask, 4'hF);

    // R8 looping stream, R6 extremes match the fixed modes
    loop_run(1, 0, 24, "R8");
    loop_run(0, 0, 0, "R8");
    loop_run(2, 0, 0, "R6");
    loop_run(2, 16, 24, "R6");
    loop_run(2, 31, 24, "R6");

    // R6 fraction with t = 2
    do_reset();
    for (int i = 0; i < WAYS; i++) do_lookup(0, 0, 1, 0, vic);
    front_cnt = 0;
    for (int n = 0; n < 400; n++) do_lookup(0, 0, 2, 2, vic);
    chk(front_cnt >= 60 && front_cnt <= 140, "R6", "front count of 400", front_cnt, 100);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule